// File: doc/BRIEF.md
# Two-Level Address Translation Cache

This block caches virtual-to-physical page translations for a core that fetches instructions and accesses data on separate paths. Each path has its own small fully associative micro translation buffer. A lookup that hits there returns the physical address in the same cycle. A lookup that misses goes to one shared main translation buffer of 128 entries, arranged as 64 sets of two ways. When the main buffer misses too, the block asks an external page-table walker for the descriptor. It writes the returned descriptor into the main buffer and forwards it to the micro buffer that asked.

Four page sizes can coexist: 4 KB, 64 KB, 1 MB and 16 MB. Each size has its own set-index function. The main buffer keeps a presence map with one bit per size, recording which sizes it has ever been filled with since the last invalidate. A main lookup probes only the sizes marked present, one size per cycle, smallest first. An empty map goes straight to the walker. One invalidate-all pulse clears all three buffers and the presence map.

The shared path is run by a four-state machine:
- **IDLE** accepts a miss. The data side wins if both sides miss. Transition IDLE→PROBE.
- **PROBE** tests one present size per cycle. A hit gives PROBE→REFILL. If no present size is left, PROBE→WALK.
- **WALK** holds the walker request until acknowledged. Transition WALK→REFILL.
- **REFILL** writes the held entry into the requesting micro buffer. Transition REFILL→IDLE.

An invalidate forces any state →IDLE.

Top module: `xlat_cache_top`

## Requirements
- R1: While a side's request is high and its micro buffer holds a matching entry, that side's hit output is 1 in the same cycle. Its physical address and attribute come from that entry, with no clock edge needed.
- R2: A micro miss that hits in the main buffer raises no walker request. The hit appears on the port after n+2 rising edges, counting from the edge that accepts the miss, where n is the position of the matching size among the present sizes.
- R3: Sizes are probed in ascending order, and only those marked present. With p sizes present and no match, the walker request rises after p+2 edges; with an empty presence map it rises after 2 edges.
- R4: The walker request stays high, with a constant address (page-aligned) and a constant ASID, until acknowledged. It drops after the acknowledging edge. The requesting side hits after the next edge.
- R5: When both sides miss in the same cycle, the data request is served first. The instruction request is served after the data refill completes.
- R6: Size codes are 0=4 KB, 1=64 KB, 2=1 MB and 3=16 MB. The physical address takes the physical page bits above the page offset and the virtual address bits below it. The set index for a size is the six virtual address bits just above that size's offset.
- R7: A non-global entry matches only when its ASID equals the current ASID. A global entry matches under any ASID.
- R8: Each main set has one recently-used bit, updated on every hit and fill. A fill goes to an invalid way if there is one; otherwise it replaces the way not used most recently.
- R9: Each micro buffer holds 8 entries and is filled in round-robin order, so the ninth fill after a clear replaces the first.
- R10: An invalidate pulse clears all micro and main entries and the presence map. No hit and no walker request appear in the following cycle, and the next miss goes to the walker after 2 edges.
- R11: A hit output is 0 while its side's request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate every entry and the presence map |
| cur_asid | input | 8 | Current address-space identifier |
| i_req | input | 1 | Instruction-side lookup request |
| i_va | input | 32 | Instruction-side virtual address |
| i_hit | output | 1 | Instruction-side translation valid |
| i_pa | output | 32 | Instruction-side physical address |
| i_attr | output | 4 | Instruction-side attribute bits |
| d_req | input | 1 | Data-side lookup request |
| d_va | input | 32 | Data-side virtual address |
| d_hit | output | 1 | Data-side translation valid |
| d_pa | output | 32 | Data-side physical address |
| d_attr | output | 4 | Data-side attribute bits |
| walk_req | output | 1 | Page-walk request |
| walk_va | output | 32 | Page-aligned address to walk |
| walk_asid | output | 8 | ASID of the walk |
| walk_ack | input | 1 | Walk result valid |
| walk_ppn | input | 20 | Physical page number returned |
| walk_size | input | 2 | Page-size code returned |
| walk_global | input | 1 | Global flag returned |
| walk_attr | input | 4 | Attribute bits returned |

## Verification
A presence map that is wrong shows up as wrong latency. A missing bit sends a cached page to the walker. An extra bit adds one probe cycle before the hit or the walk. The bench therefore counts edges on every miss, and any such state error is visible within a few cycles. A wrong recently-used bit or round-robin pointer evicts the wrong entry. That shows up later, as a walker request (or a missing same-cycle hit) for a page that should still be held. An invalidate that leaves a single valid bit set shows up at once, as a hit or a skipped walk on the first access after the pulse.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = 20;
    localparam int VA_W   = OFF_W + VPN_W;
    localparam int PPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int ATTR_W = 4;
    localparam int NSIZE  = 4;
    localparam int SIZE_STEP = 4;

    typedef logic [1:0] psize_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        psize_t            size;
        logic [ATTR_W-1:0] attr;
    } xent_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_WALK, ST_REFILL} mst_t;

    // bits of the page number that lie inside the page offset for this size
    function automatic logic [VPN_W-1:0] size_mask(input psize_t s);
        logic [VPN_W-1:0] m;
        m = '0;
        for (int b = 0; b < VPN_W; b++)
            if (b < SIZE_STEP * int'(s)) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic ent_match(input xent_t e, input logic [VPN_W-1:0] vpn,
                                       input logic [ASID_W-1:0] asid);
        logic [VPN_W-1:0] m;
        m = size_mask(e.size);
        return e.valid && (e.glob || (e.asid == asid)) && (((e.vpn ^ vpn) & ~m) == '0);
    endfunction

    function automatic logic [VPN_W-1:0] ent_page(input xent_t e, input logic [VPN_W-1:0] vpn);
        logic [VPN_W-1:0] m;
        m = size_mask(e.size);
        return (e.ppn & ~m) | (vpn & m);
    endfunction
endpackage

// File: rtl/xlat_utlb.sv
module xlat_utlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [VPN_W-1:0]  lk_page,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_en,
    input  xent_t             fill_ent
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    xent_t              ent [ENTRIES];
    logic [PTR_W-1:0]   rr;
    logic [ENTRIES-1:0] hitv;

    generate
        for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
            assign hitv[k] = ent_match(ent[k], lk_vpn, lk_asid);
        end
    endgenerate

    always_comb begin
        lk_hit  = |hitv;
        lk_page = '0;
        lk_attr = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (hitv[k]) begin
                lk_page = ent_page(ent[k], lk_vpn);
                lk_attr = ent[k].attr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int k = 0; k < ENTRIES; k++) ent[k].valid <= 1'b0;
            rr <= '0;
        end else if (fill_en) begin
            ent[rr] <= fill_ent;
            rr      <= (rr == PTR_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_mtlb.sv
module xlat_mtlb
    import xlat_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  psize_t            pr_size,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    input  logic              pr_touch,
    output logic              pr_hit,
    output xent_t             pr_ent,
    input  logic              wr_en,
    input  xent_t             wr_ent,
    output logic [NSIZE-1:0]  hitmap
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAYS  = 2;

    xent_t            mem [WAYS][SETS];
    logic [SETS-1:0]  lru;          // way to replace next
    logic [IDX_W-1:0] pr_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [WAYS-1:0]  way_hit;
    logic             pr_way;
    logic             victim;

    function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] v, input psize_t s);
        return IDX_W'(v >> (SIZE_STEP * int'(s)));
    endfunction

    assign pr_idx = set_of(pr_vpn, pr_size);
    assign wr_idx = set_of(wr_ent.vpn, wr_ent.size);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign way_hit[w] = ent_match(mem[w][pr_idx], pr_vpn, pr_asid);
        end
    endgenerate

    assign pr_hit = |way_hit;
    assign pr_way = !way_hit[0];
    assign pr_ent = way_hit[0] ? mem[0][pr_idx] : mem[1][pr_idx];

    always_comb begin
        if (!mem[0][wr_idx].valid)      victim = 1'b0;
        else if (!mem[1][wr_idx].valid) victim = 1'b1;
        else                            victim = lru[wr_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++) mem[w][s].valid <= 1'b0;
            lru    <= '0;
            hitmap <= '0;
        end else begin
            if (wr_en) begin
                mem[victim][wr_idx]  <= wr_ent;
                lru[wr_idx]          <= !victim;
                hitmap[wr_ent.size]  <= 1'b1;
            end
            if (pr_touch) lru[pr_idx] <= !pr_way;
        end
    end
endmodule

// File: rtl/xlat_cache_top.sv
module xlat_cache_top
    import xlat_pkg::*;
#(
    parameter int UT_ENTRIES = 8,
    parameter int MT_SETS    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              i_req,
    input  logic [VA_W-1:0]   i_va,
    output logic              i_hit,
    output logic [VA_W-1:0]   i_pa,
    output logic [ATTR_W-1:0] i_attr,
    input  logic              d_req,
    input  logic [VA_W-1:0]   d_va,
    output logic              d_hit,
    output logic [VA_W-1:0]   d_pa,
    output logic [ATTR_W-1:0] d_attr,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_va,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              walk_ack,
    input  logic [PPN_W-1:0]  walk_ppn,
    input  psize_t            walk_size,
    input  logic              walk_global,
    input  logic [ATTR_W-1:0] walk_attr
);
    logic              iu_hit, du_hit;
    logic [VPN_W-1:0]  iu_page, du_page;
    logic              iu_fill, du_fill;
    mst_t              state, state_nx;
    logic              side_d;
    logic [VPN_W-1:0]  req_vpn;
    logic [ASID_W-1:0] req_asid;
    logic [NSIZE-1:0]  pmask;
    xent_t             held;
    xent_t             walk_ent;
    logic [NSIZE-1:0]  hitmap;
    logic              pr_hit;
    xent_t             pr_ent;
    psize_t            pr_size;
    logic              take_d, take_i;
    logic              mt_wr, mt_touch;

    xlat_utlb #(.ENTRIES(UT_ENTRIES)) u_itlb (
        .clk(clk), .rst_n(rst_n), .flush(inv_all),
        .lk_vpn(i_va[VA_W-1:OFF_W]), .lk_asid(cur_asid),
        .lk_hit(iu_hit), .lk_page(iu_page), .lk_attr(i_attr),
        .fill_en(iu_fill), .fill_ent(held)
    );

    xlat_utlb #(.ENTRIES(UT_ENTRIES)) u_dtlb (
        .clk(clk), .rst_n(rst_n), .flush(inv_all),
        .lk_vpn(d_va[VA_W-1:OFF_W]), .lk_asid(cur_asid),
        .lk_hit(du_hit), .lk_page(du_page), .lk_attr(d_attr),
        .fill_en(du_fill), .fill_ent(held)
    );

    xlat_mtlb #(.SETS(MT_SETS)) u_main (
        .clk(clk), .rst_n(rst_n), .flush(inv_all),
        .pr_size(pr_size), .pr_vpn(req_vpn), .pr_asid(req_asid),
        .pr_touch(mt_touch), .pr_hit(pr_hit), .pr_ent(pr_ent),
        .wr_en(mt_wr), .wr_ent(walk_ent), .hitmap(hitmap)
    );

    assign i_hit = i_req && iu_hit;
    assign d_hit = d_req && du_hit;
    assign i_pa  = {iu_page, i_va[OFF_W-1:0]};
    assign d_pa  = {du_page, d_va[OFF_W-1:0]};

    // data side has fixed priority
    assign take_d = d_req && !du_hit;
    assign take_i = i_req && !iu_hit && !take_d;

    // smallest present size still to probe
    always_comb begin
        pr_size = psize_t'(0);
        for (int s = NSIZE - 1; s >= 0; s--)
            if (pmask[s]) pr_size = psize_t'(s);
    end

    always_comb begin
        walk_ent       = '0;
        walk_ent.valid = 1'b1;
        walk_ent.vpn   = req_vpn;
        walk_ent.ppn   = walk_ppn;
        walk_ent.asid  = req_asid;
        walk_ent.glob  = walk_global;
        walk_ent.size  = walk_size;
        walk_ent.attr  = walk_attr;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take_d || take_i) state_nx = ST_PROBE;
            ST_PROBE:  if (pmask == '0)      state_nx = ST_WALK;
                       else if (pr_hit)      state_nx = ST_REFILL;
            ST_WALK:   if (walk_ack)         state_nx = ST_REFILL;
            ST_REFILL:                       state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
        if (inv_all) state_nx = ST_IDLE;
    end

    // outputs
    always_comb begin
        walk_req  = (state == ST_WALK);
        walk_va   = {req_vpn, {OFF_W{1'b0}}};
        walk_asid = req_asid;
        mt_touch  = (state == ST_PROBE) && (pmask != '0) && pr_hit && !inv_all;
        mt_wr     = (state == ST_WALK) && walk_ack && !inv_all;
        iu_fill   = (state == ST_REFILL) && !side_d;
        du_fill   = (state == ST_REFILL) && side_d;
    end

    // request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_d   <= 1'b0;
            req_vpn  <= '0;
            req_asid <= '0;
            pmask    <= '0;
            held     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (take_d || take_i) begin
                    side_d   <= take_d;
                    req_vpn  <= take_d ? d_va[VA_W-1:OFF_W] : i_va[VA_W-1:OFF_W];
                    req_asid <= cur_asid;
                    pmask    <= hitmap;
                end
                ST_PROBE: if (pmask != '0) begin
                    if (pr_hit) held           <= pr_ent;
                    else        pmask[pr_size] <= 1'b0;
                end
                ST_WALK:   if (walk_ack) held <= walk_ent;
                ST_REFILL: ;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              i_hit,
    input logic              d_hit,
    input logic              walk_req,
    input logic [VA_W-1:0]   walk_va,
    input logic [ASID_W-1:0] walk_asid,
    input logic              walk_ack
);
    p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_ack && !inv_all |=> walk_req);

    p_walk_va_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_ack && !inv_all |=> $stable(walk_va));

    p_walk_asid_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_ack && !inv_all |=> $stable(walk_asid));

    p_walk_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_ack |=> !walk_req);

    p_flush_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !i_hit && !d_hit);

    p_flush_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !walk_req);
endmodule

bind xlat_cache_top xlat_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .i_hit(i_hit), .d_hit(d_hit),
    .walk_req(walk_req), .walk_va(walk_va), .walk_asid(walk_asid), .walk_ack(walk_ack)
);

// File: tb/sim_xlat_cache_top.sv
module sim_xlat_cache_top;
    logic        clk = 1'b0;
    logic        rst_n, inv_all;
    logic [7:0]  cur_asid;
    logic        i_req, d_req, i_hit, d_hit;
    logic [31:0] i_va, d_va, i_pa, d_pa;
    logic [3:0]  i_attr, d_attr;
    logic        walk_req, walk_ack, walk_global;
    logic [31:0] walk_va;
    logic [7:0]  walk_asid;
    logic [19:0] walk_ppn;
    logic [1:0]  walk_size;
    logic [3:0]  walk_attr;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    xlat_cache_top u0 (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .cur_asid(cur_asid),
        .i_req(i_req), .i_va(i_va), .i_hit(i_hit), .i_pa(i_pa), .i_attr(i_attr),
        .d_req(d_req), .d_va(d_va), .d_hit(d_hit), .d_pa(d_pa), .d_attr(d_attr),
        .walk_req(walk_req), .walk_va(walk_va), .walk_asid(walk_asid), .walk_ack(walk_ack),
        .walk_ppn(walk_ppn), .walk_size(walk_size), .walk_global(walk_global), .walk_attr(walk_attr)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit sd, input bit on, input logic [31:0] va);
        if (sd) begin d_req = on; d_va = va; end
        else    begin i_req = on; i_va = va; end
    endtask

    function automatic logic hit_of(input bit sd);
        return sd ? d_hit : i_hit;
    endfunction

    function automatic logic [31:0] pa_of(input bit sd);
        return sd ? d_pa : i_pa;
    endfunction

    function automatic logic [31:0] exp_pa(input logic [19:0] ppn, input logic [1:0] sz,
                                           input logic [31:0] va);
        logic [31:0] keep;
        keep = (32'h1 << (12 + 4 * int'(sz))) - 32'h1;
        return ({ppn, 12'h000} & ~keep) | (va & keep);
    endfunction

    task automatic edges_to_walk(output int n);
        n = 0;
        while (!walk_req && n < 40) begin tick; n++; end
    endtask

    task automatic edges_to_hit(input bit sd, output int n, output bit walked);
        n = 0; walked = 0;
        while (!hit_of(sd) && n < 40) begin
            tick; n++;
            if (walk_req) walked = 1;
        end
    endtask

    task automatic answer(input logic [19:0] ppn, input logic [1:0] sz, input bit g,
                          input logic [3:0] at);
        walk_ack = 1'b1; walk_ppn = ppn; walk_size = sz; walk_global = g; walk_attr = at;
        tick;
        walk_ack = 1'b0;
    endtask

    task automatic walk_fill(input bit sd, input logic [31:0] va, input logic [19:0] ppn,
                             input logic [1:0] sz, input bit g, input logic [3:0] at,
                             input int exp_n, input string tag);
        int n;
        drive(sd, 1'b1, va);
        edges_to_walk(n);
        expect_eq({tag, " walk latency"}, n, exp_n);
        expect_eq({tag, " walk address R4"}, walk_va, {va[31:12], 12'h000});
        answer(ppn, sz, g, at);
        tick;
        expect_eq({tag, " hit after fill R4"}, hit_of(sd), 1'b1);
        expect_eq({tag, " pa after fill R6"}, pa_of(sd), exp_pa(ppn, sz, va));
        drive(sd, 1'b0, va);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; inv_all = 1'b0; cur_asid = 8'd5;
        i_req = 0; d_req = 0; i_va = 0; d_va = 0;
        walk_ack = 0; walk_ppn = 0; walk_size = 0; walk_global = 0; walk_attr = 0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        expect_eq("R11 reset i_hit", i_hit, 1'b0);
        expect_eq("R11 reset d_hit", d_hit, 1'b0);
        expect_eq("R4 reset walk_req", walk_req, 1'b0);
    endtask

    task automatic t_cold;
        int n;
        drive(1, 1, 32'h1234_5678);
        #1;
        expect_eq("R11 cold miss d_hit", d_hit, 1'b0);
        edges_to_walk(n);
        expect_eq("R3 empty map walk latency", n, 2);
        expect_eq("R4 walk_va", walk_va, 32'h1234_5000);
        expect_eq("R4 walk_asid", walk_asid, 32'd5);
        repeat (3) tick;
        expect_eq("R4 walk_req held", walk_req, 1'b1);
        expect_eq("R4 walk_va held", walk_va, 32'h1234_5000);
        answer(20'hABCDE, 2'd0, 1'b0, 4'h3);
        expect_eq("R4 walk_req drops", walk_req, 1'b0);
        tick;
        expect_eq("R4 d_hit after fill", d_hit, 1'b1);
        expect_eq("R6 d_pa 4K", d_pa, 32'hABCD_E678);
        expect_eq("R4 d_attr", d_attr, 32'h3);
    endtask

    task automatic t_uhit;
        d_va = 32'h1234_5ABC;
        #1;
        expect_eq("R1 same-cycle hit", d_hit, 1'b1);
        expect_eq("R1 same-cycle pa", d_pa, 32'hABCD_EABC);
        d_req = 1'b0;
        #1;
        expect_eq("R11 no hit without req", d_hit, 1'b0);
    endtask

    task automatic t_main_hit;
        int n; bit w;
        drive(0, 1, 32'h1234_5010);
        edges_to_hit(0, n, w);
        expect_eq("R2 main hit latency", n, 3);
        expect_eq("R2 no walk on main hit", w, 1'b0);
        expect_eq("R2 i_pa", i_pa, 32'hABCD_E010);
        expect_eq("R2 i_attr", i_attr, 32'h3);
        drive(0, 0, 0);
    endtask

    task automatic t_hitmap;
        int n; bit w;
        walk_fill(1, 32'h400A_BCDE, 20'h80000, 2'd2, 1'b0, 4'h5, 3, "R3 one size present");
        drive(0, 1, 32'h4001_2345);
        edges_to_hit(0, n, w);
        expect_eq("R3 second present size latency", n, 4);
        expect_eq("R3 no walk", w, 1'b0);
        expect_eq("R6 1M pa", i_pa, 32'h8001_2345);
        drive(0, 0, 0);
        walk_fill(1, 32'h7A12_3456, 20'h99000, 2'd3, 1'b0, 4'h6, 4, "R3 two sizes present");
        drive(0, 1, 32'h7AFF_F000);
        edges_to_hit(0, n, w);
        expect_eq("R3 absent 64K size skipped", n, 5);
        expect_eq("R6 16M pa", i_pa, 32'h99FF_F000);
        drive(0, 0, 0);
    endtask

    task automatic t_asid;
        int n; bit w;
        cur_asid = 8'd6;
        drive(1, 1, 32'h1234_5345);
        #1;
        expect_eq("R7 foreign ASID misses", d_hit, 1'b0);
        walk_fill(1, 32'h1234_5345, 20'h55555, 2'd0, 1'b1, 4'h1, 5, "R7 global fill");
        cur_asid = 8'd7;
        drive(0, 1, 32'h1234_5345);
        edges_to_hit(0, n, w);
        expect_eq("R7 global main hit latency", n, 3);
        expect_eq("R7 global pa", i_pa, 32'h5555_5345);
        drive(0, 0, 0);
        cur_asid = 8'd5;
    endtask

    task automatic t_priority;
        int n;
        drive(0, 1, 32'h0070_1000);
        drive(1, 1, 32'h0080_2000);
        edges_to_walk(n);
        expect_eq("R5 data walked first", walk_va, 32'h0080_2000);
        answer(20'h11111, 2'd0, 1'b0, 4'h0);
        tick;
        expect_eq("R5 data hit", d_hit, 1'b1);
        edges_to_walk(n);
        expect_eq("R5 instruction walked next", walk_va, 32'h0070_1000);
        answer(20'h22222, 2'd0, 1'b0, 4'h0);
        tick;
        expect_eq("R5 instruction hit", i_hit, 1'b1);
        expect_eq("R5 instruction pa", i_pa, 32'h2222_2000);
        drive(0, 0, 0);
        drive(1, 0, 0);
    endtask

    task automatic t_lru;
        int n; bit w;
        walk_fill(1, 32'h0001_0000, 20'h0A000, 2'd0, 1'b0, 4'h0, 5, "R8 fill A");
        walk_fill(1, 32'h1001_0000, 20'h0B000, 2'd0, 1'b0, 4'h0, 5, "R8 fill B");
        drive(0, 1, 32'h0001_0000);
        edges_to_hit(0, n, w);
        expect_eq("R8 touch A main hit", n, 3);
        drive(0, 0, 0);
        walk_fill(1, 32'h2001_0000, 20'h0C000, 2'd0, 1'b0, 4'h0, 5, "R8 fill C");
        drive(0, 1, 32'h1001_0000);
        edges_to_walk(n);
        expect_eq("R8 B evicted needs walk", n, 5);
        answer(20'h0B000, 2'd0, 1'b0, 4'h0);
        tick;
        expect_eq("R8 B refetched pa", i_pa, 32'h0B00_0000);
        drive(0, 0, 0);
    endtask

    task automatic t_flush;
        int n;
        inv_all = 1'b1;
        tick;
        inv_all = 1'b0;
        drive(1, 1, 32'h1234_5678);
        #1;
        expect_eq("R10 micro cleared", d_hit, 1'b0);
        edges_to_walk(n);
        expect_eq("R10 map cleared walk latency", n, 2);
        answer(20'hABCDE, 2'd0, 1'b0, 4'h3);
        tick;
        expect_eq("R10 refill after flush", d_pa, 32'hABCD_E678);
        drive(1, 0, 0);
    endtask

    task automatic t_round_robin;
        int n; bit w;
        for (int k = 0; k < 8; k++)
            walk_fill(1, 32'h3000_0000 + (k << 12), 20'h60000 + k, 2'd0, 1'b0, 4'h0, 3,
                      "R9 fill");
        drive(1, 1, 32'h1234_5678);
        #1;
        expect_eq("R9 ninth fill evicted first", d_hit, 1'b0);
        edges_to_hit(1, n, w);
        expect_eq("R9 evicted page from main", n, 3);
        expect_eq("R9 no walk", w, 1'b0);
        d_va = 32'h3000_1000;
        #1;
        expect_eq("R9 later entry kept", d_hit, 1'b1);
        expect_eq("R9 later entry pa", d_pa, 32'h6000_1000);
        drive(1, 0, 0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_cold();
        t_uhit();
        t_main_hit();
        t_hitmap();
        t_asid();
        t_priority();
        t_lru();
        t_flush();
        t_round_robin();
        finish_run();
    end
endmodule